// File: doc/BRIEF.md
# Debug Trigger Event Generator

This block watches a wide debug bus together with three status strobes and one software-controlled bit, and emits a single-cycle trigger pulse that starts a capture engine. Three trigger styles are available. A single selected bus bit can be watched for a chosen edge. The whole bus, after masking, can be compared against a reference word. Alternatively, a rising edge on one of four event sources can start the capture: packet check passed, packet check failed, channel busy, or a software bit.

Software sets the configuration inputs and then pulses the arm input. The configuration is captured on that pulse. At most one trigger pulse follows each arming. All watched inputs pass through a register pipeline before edge detection. The history used for edge detection follows the pipelined input at all times, so a level that is already present when the block is armed never counts as an edge.

Top module: `dbg_trig_gen`

## Requirements
- R1: After reset, `trig_o` and `armed_o` are both 0.
- R2: A cycle with `arm_i`=1 and `disarm_i`=0 captures every configuration input and sets `armed_o` on the next cycle, and no trigger is emitted for that cycle. A cycle with `disarm_i`=1 clears `armed_o` on the next cycle and suppresses any trigger. `disarm_i` takes priority over `arm_i`.
- R3: `trig_o` is high for exactly one cycle, and `armed_o` falls in that same cycle. No further pulse follows until the block is armed again.
- R4: In bit mode (mode code 0) with edge select 0, a rising edge on bus bit `cfg_bit_sel_i` fires. With the default two pipeline stages, `trig_o` rises on the third rising clock edge after the bus changes. Changes on other bits and falling edges on the selected bit do not fire.
- R5: In bit mode with edge select 1, only a falling edge on the selected bit fires, with the same latency as R4.
- R6: In word mode (mode code 1), the block fires on the first armed cycle in which `(bus & mask) == (ref & mask)`. Reference bits outside the mask are don't-care, and an all-zero mask fires one cycle after arming.
- R7: In word mode, the bit-select input has no effect on the result.
- R8: In event mode (mode code 2), source code 0 selects packet-check-OK, 1 selects packet-check-fail and 2 selects channel-busy. Only a 0-to-1 transition of the selected strobe fires, with the R4 latency. Other strobes are ignored.
- R9: In event mode with source code 3, a 0-to-1 write of `sw_trig_i` fires with the R4 latency. Holding the bit at 1, or clearing it, does not fire.
- R10: A watched bit or strobe that is already in its post-edge state when arming takes place does not fire.
- R11: Mode code 3 never fires, and the block stays armed.
- R12: Changes to the configuration inputs after arming have no effect until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Capture configuration and arm |
| disarm_i | input | 1 | Disarm; overrides arm |
| cfg_mode_i | input | 2 | 0 bit edge, 1 word match, 2 event, 3 reserved |
| cfg_bit_sel_i | input | 5 | Bus bit watched in bit mode |
| cfg_edge_neg_i | input | 1 | 0 rising edge, 1 falling edge |
| cfg_mask_i | input | 32 | Word-match mask |
| cfg_ref_i | input | 32 | Word-match reference |
| cfg_evt_src_i | input | 2 | 0 packet OK, 1 packet fail, 2 channel busy, 3 software |
| sw_trig_i | input | 1 | Software trigger bit |
| dbg_bus_i | input | 32 | Debug bus |
| pkt_ok_i | input | 1 | Packet check passed strobe |
| pkt_fail_i | input | 1 | Packet check failed strobe |
| chan_busy_i | input | 1 | Channel busy indication |
| armed_o | output | 1 | Block is armed |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench sweeps every bit position with both edge polarities. For each combination it first presents the post-edge level at arming, then the opposite edge, then toggles on every other bit. A design that seeded its edge history wrongly would fire at arming. A design with a swapped polarity or a mis-indexed select would fire early or never. In word mode, reference bits outside the mask differ from the bus, which catches a compare that ignores the mask. Each event source is tested against pulses on the other sources and on the software bit. Late changes to the configuration after arming are also tested, which exposes a design that reads the live inputs instead of the captured copy.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   // Event-source vector layout: bit index equals the source code.
   localparam int EVT_N = 4;

   typedef enum logic [1:0] {
      MODE_BIT  = 2'd0,
      MODE_WORD = 2'd1,
      MODE_EVT  = 2'd2,
      MODE_RSVD = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      SRC_PKT_OK   = 2'd0,
      SRC_PKT_FAIL = 2'd1,
      SRC_BUSY     = 2'd2,
      SRC_SW       = 2'd3
   } evt_src_e;

endpackage

// File: rtl/dbg_trig_sync.sv
// Register pipeline for the watched inputs plus a history stage that
// always follows the pipeline output, so no stale value survives arming.
module dbg_trig_sync #(
   parameter int W      = 36,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("dbg_trig_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[i] <= '0;
         end else begin
            if (i == 0) stg[i] <= d_i;
            else        stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   end

   logic [W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= stg[STAGES-1];
   end

   assign cur_o  = stg[STAGES-1];
   assign prev_o = hist_q;

endmodule

// File: rtl/dbg_trig_cfg.sv
// Configuration snapshot taken on each arm.
module dbg_trig_cfg
   import dbg_trig_pkg::*;
#(
   parameter int DBG_W = 32,
   localparam int SEL_W = $clog2(DBG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [1:0]       mode_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             neg_i,
   input  logic [DBG_W-1:0] mask_i,
   input  logic [DBG_W-1:0] ref_i,
   input  logic [1:0]       src_i,
   output trig_mode_e       mode_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             neg_o,
   output logic [DBG_W-1:0] mask_o,
   output logic [DBG_W-1:0] ref_o,
   output evt_src_e         src_o
);

   trig_mode_e mode_in;
   assign mode_in = trig_mode_e'(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= MODE_RSVD;
         sel_o  <= '0;
         neg_o  <= 1'b0;
         mask_o <= '0;
         ref_o  <= '0;
         src_o  <= SRC_PKT_OK;
      end else if (load_i) begin
         mode_o <= mode_in;
         // bit select carries no meaning in word mode: store zero
         sel_o  <= (mode_in == MODE_WORD) ? '0 : sel_i;
         neg_o  <= neg_i;
         mask_o <= mask_i;
         ref_o  <= ref_i & mask_i;
         src_o  <= evt_src_e'(src_i);
      end
   end

endmodule

// File: rtl/dbg_trig_detect.sv
// Combinational trigger condition from pipelined and history values.
module dbg_trig_detect
   import dbg_trig_pkg::*;
#(
   parameter int DBG_W = 32,
   localparam int SEL_W = $clog2(DBG_W)
) (
   input  logic [DBG_W-1:0] cur_bus_i,
   input  logic [DBG_W-1:0] prev_bus_i,
   input  logic [EVT_N-1:0] cur_evt_i,
   input  logic [EVT_N-1:0] prev_evt_i,
   input  trig_mode_e       mode_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             neg_i,
   input  logic [DBG_W-1:0] mask_i,
   input  logic [DBG_W-1:0] ref_i,
   input  evt_src_e         src_i,
   output logic             hit_o
);

   logic [EVT_N-1:0] evt_rise;
   logic             bit_cur, bit_prev, bit_edge, word_eq;

   for (genvar e = 0; e < EVT_N; e++) begin : g_evt_edge
      assign evt_rise[e] = cur_evt_i[e] & ~prev_evt_i[e];
   end

   assign bit_cur  = cur_bus_i[sel_i];
   assign bit_prev = prev_bus_i[sel_i];
   assign bit_edge = neg_i ? (bit_prev & ~bit_cur) : (bit_cur & ~bit_prev);
   assign word_eq  = ((cur_bus_i & mask_i) == ref_i);

   always_comb begin
      unique case (mode_i)
         MODE_BIT:  hit_o = bit_edge;
         MODE_WORD: hit_o = word_eq;
         MODE_EVT:  hit_o = evt_rise[src_i];
         default:   hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/dbg_trig_ctrl.sv
// Arm state and registered one-shot trigger.
module dbg_trig_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic disarm_i,
   input  logic hit_i,
   output logic load_o,
   output logic armed_o,
   output logic trig_o
);

   logic armed_q, trig_q, fire;

   assign load_o = arm_i & ~disarm_i;
   assign fire   = armed_q & hit_i & ~arm_i & ~disarm_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         trig_q  <= 1'b0;
      end else begin
         trig_q <= fire;
         if (disarm_i)  armed_q <= 1'b0;
         else if (arm_i) armed_q <= 1'b1;
         else if (fire)  armed_q <= 1'b0;
      end
   end

   assign armed_o = armed_q;
   assign trig_o  = trig_q;

endmodule

// File: rtl/dbg_trig_gen.sv
module dbg_trig_gen
   import dbg_trig_pkg::*;
#(
   parameter int DBG_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm_i,
   input  logic                     disarm_i,
   input  logic [1:0]               cfg_mode_i,
   input  logic [$clog2(DBG_W)-1:0] cfg_bit_sel_i,
   input  logic                     cfg_edge_neg_i,
   input  logic [DBG_W-1:0]         cfg_mask_i,
   input  logic [DBG_W-1:0]         cfg_ref_i,
   input  logic [1:0]               cfg_evt_src_i,
   input  logic                     sw_trig_i,
   input  logic [DBG_W-1:0]         dbg_bus_i,
   input  logic                     pkt_ok_i,
   input  logic                     pkt_fail_i,
   input  logic                     chan_busy_i,
   output logic                     armed_o,
   output logic                     trig_o
);

   localparam int SEL_W = $clog2(DBG_W);
   localparam int IN_W  = DBG_W + EVT_N;

   if (DBG_W < 2 || (1 << SEL_W) != DBG_W) begin : g_bad_width
      $error("dbg_trig_gen: DBG_W must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dbg_trig_gen: SYNC_STAGES must be at least 1");
   end

   // event vector: index equals source code
   logic [EVT_N-1:0] evt_raw;
   assign evt_raw = {sw_trig_i, chan_busy_i, pkt_fail_i, pkt_ok_i};

   logic [IN_W-1:0] cur_all, prev_all;

   dbg_trig_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    ({evt_raw, dbg_bus_i}),
      .cur_o  (cur_all),
      .prev_o (prev_all)
   );

   logic             load;
   trig_mode_e       mode_q;
   logic [SEL_W-1:0] sel_q;
   logic             neg_q;
   logic [DBG_W-1:0] mask_q, ref_q;
   evt_src_e         src_q;

   dbg_trig_cfg #(.DBG_W(DBG_W)) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .mode_i (cfg_mode_i),
      .sel_i  (cfg_bit_sel_i),
      .neg_i  (cfg_edge_neg_i),
      .mask_i (cfg_mask_i),
      .ref_i  (cfg_ref_i),
      .src_i  (cfg_evt_src_i),
      .mode_o (mode_q),
      .sel_o  (sel_q),
      .neg_o  (neg_q),
      .mask_o (mask_q),
      .ref_o  (ref_q),
      .src_o  (src_q)
   );

   logic hit;

   dbg_trig_detect #(.DBG_W(DBG_W)) i_detect (
      .cur_bus_i  (cur_all[DBG_W-1:0]),
      .prev_bus_i (prev_all[DBG_W-1:0]),
      .cur_evt_i  (cur_all[IN_W-1:DBG_W]),
      .prev_evt_i (prev_all[IN_W-1:DBG_W]),
      .mode_i     (mode_q),
      .sel_i      (sel_q),
      .neg_i      (neg_q),
      .mask_i     (mask_q),
      .ref_i      (ref_q),
      .src_i      (src_q),
      .hit_o      (hit)
   );

   dbg_trig_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm_i),
      .disarm_i (disarm_i),
      .hit_i    (hit),
      .load_o   (load),
      .armed_o  (armed_o),
      .trig_o   (trig_o)
   );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
   input logic clk,
   input logic rst_n,
   input logic arm_i,
   input logic disarm_i,
   input logic armed_o,
   input logic trig_o
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o); // R3
   AST_TRIG_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> !armed_o); // R3
   AST_TRIG_WAS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && trig_o) |-> $past(armed_o)); // R3
   AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(arm_i && !disarm_i)) |-> (armed_o && !trig_o)); // R2
   AST_DISARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(disarm_i)) |-> (!armed_o && !trig_o)); // R2

endmodule

bind dbg_trig_gen dbg_trig_chk i_dbg_trig_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm_i    (arm_i),
   .disarm_i (disarm_i),
   .armed_o  (armed_o),
   .trig_o   (trig_o)
);

// File: tb/test_dbg_trig_gen.sv
`timescale 1ns/1ps
module test_dbg_trig_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm_i = 1'b0, disarm_i = 1'b0;
   logic [1:0]  cfg_mode_i = '0;
   logic [4:0]  cfg_bit_sel_i = '0;
   logic        cfg_edge_neg_i = 1'b0;
   logic [31:0] cfg_mask_i = '0, cfg_ref_i = '0;
   logic [1:0]  cfg_evt_src_i = '0;
   logic        sw_trig_i = 1'b0;
   logic [31:0] dbg_bus_i = '0;
   logic        pkt_ok_i = 1'b0, pkt_fail_i = 1'b0, chan_busy_i = 1'b0;
   logic        armed_o, trig_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dbg_trig_gen i_dbg_trig_gen (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
      .cfg_mode_i(cfg_mode_i), .cfg_bit_sel_i(cfg_bit_sel_i),
      .cfg_edge_neg_i(cfg_edge_neg_i), .cfg_mask_i(cfg_mask_i),
      .cfg_ref_i(cfg_ref_i), .cfg_evt_src_i(cfg_evt_src_i),
      .sw_trig_i(sw_trig_i), .dbg_bus_i(dbg_bus_i), .pkt_ok_i(pkt_ok_i),
      .pkt_fail_i(pkt_fail_i), .chan_busy_i(chan_busy_i),
      .armed_o(armed_o), .trig_o(trig_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch(input int n, output logic seen);
      seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         seen = seen | trig_o;
      end
   endtask

   task automatic do_arm(input logic [1:0] m, input logic [4:0] s, input logic ng,
                         input logic [31:0] mk, input logic [31:0] rf,
                         input logic [1:0] src);
      cfg_mode_i = m; cfg_bit_sel_i = s; cfg_edge_neg_i = ng;
      cfg_mask_i = mk; cfg_ref_i = rf; cfg_evt_src_i = src;
      arm_i = 1'b1;
      tick(1);
      arm_i = 1'b0;
   endtask

   task automatic set_evt(input int idx, input logic v);
      case (idx)
         0: pkt_ok_i = v;
         1: pkt_fail_i = v;
         2: chan_busy_i = v;
         default: sw_trig_i = v;
      endcase
   endtask

   // called right after the watched input changed; lat = ticks until trig_o
   task automatic expect_fire(input string req, input int lat);
      tick(lat - 1);
      check(req, "before fire", trig_o, 0);
      tick(1);
      check(req, "fire", trig_o, 1);
      check("R3", "armed at fire", armed_o, 0);
      tick(1);
      check("R3", "pulse width", trig_o, 0);
   endtask

   initial begin
      #500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic seen;
      logic [31:0] masks [3];
      logic [31:0] refs [3];
      logic [4:0]  sels [3];
      masks[0] = 32'hFFFF_FFFF; refs[0] = 32'h1234_5678;
      masks[1] = 32'h0000_FF00; refs[1] = 32'h0000_AB00;
      masks[2] = 32'h8000_0001; refs[2] = 32'h8000_0001;
      sels[0] = 5'd0; sels[1] = 5'd17; sels[2] = 5'd31;

      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R1", "trig after reset", trig_o, 0);
      check("R1", "armed after reset", armed_o, 0);

      // bit mode: every position, both polarities
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 2; p++) begin
            logic [31:0] one, bus;
            string rq;
            one = 32'd1 << s;
            rq  = (p == 1) ? "R5" : "R4";
            bus = 32'h6B2D_94E1 ^ (32'h0101_0101 * s);
            bus = (p == 1) ? (bus & ~one) : (bus | one);  // post-edge level
            dbg_bus_i = bus;
            tick(4);
            do_arm(2'd0, 5'(s), 1'(p), 32'hFFFF_FFFF, 32'h0, 2'd0);
            check("R2", "armed after arm", armed_o, 1);
            watch(4, seen);
            check("R10", "level present at arm", seen, 0);
            dbg_bus_i = dbg_bus_i ^ ~one;
            watch(4, seen);
            check(rq, "other bits toggle", seen, 0);
            dbg_bus_i = dbg_bus_i ^ one;          // opposite edge
            watch(4, seen);
            check(rq, "opposite edge", seen, 0);
            dbg_bus_i = dbg_bus_i ^ one;          // chosen edge
            expect_fire(rq, 3);
            dbg_bus_i = dbg_bus_i ^ one;
            tick(1);
            dbg_bus_i = dbg_bus_i ^ one;
            watch(5, seen);
            check("R3", "no second pulse", seen, 0);
         end
      end

      // word match
      for (int i = 0; i < 3; i++) begin
         for (int j = 0; j < 3; j++) begin
            logic [31:0] mk, rf, low;
            mk = masks[i]; rf = refs[i];
            low = mk & (~mk + 32'd1);
            dbg_bus_i = ((rf & mk) ^ low) | (~mk & 32'h3333_3333);
            tick(4);
            do_arm(2'd1, sels[j], 1'(j), mk, rf ^ (~mk & 32'h0F0F_0F0F), 2'd0);
            watch(4, seen);
            check("R6", "mismatch in one bit", seen, 0);
            dbg_bus_i = (rf & mk) | (~mk & 32'hCCCC_CCCC);
            expect_fire((j == 0) ? "R6" : "R7", 3);
         end
      end
      // all-zero mask: fires one cycle after arming
      dbg_bus_i = 32'hDEAD_BEEF;
      tick(4);
      do_arm(2'd1, 5'd9, 1'b0, 32'h0, 32'hFFFF_FFFF, 2'd0);
      check("R6", "zero mask, arm cycle", trig_o, 0);
      tick(1);
      check("R6", "zero mask fires", trig_o, 1);
      tick(1);

      // event sources
      for (int src = 0; src < 4; src++) begin
         string rq;
         rq = (src == 3) ? "R9" : "R8";
         set_evt(src, 1'b1);
         tick(4);
         do_arm(2'd2, 5'd0, 1'b0, 32'h0, 32'h0, 2'(src));
         watch(4, seen);
         check("R10", "source high at arm", seen, 0);
         set_evt(src, 1'b0);
         watch(4, seen);
         check(rq, "falling source", seen, 0);
         for (int o = 0; o < 4; o++) begin
            if (o != src) begin
               set_evt(o, 1'b1);
               tick(1);
               set_evt(o, 1'b0);
            end
         end
         watch(5, seen);
         check(rq, "other sources", seen, 0);
         set_evt(src, 1'b1);
         tick(1);
         if (src != 3) set_evt(src, 1'b0);
         expect_fire(rq, 2);
         set_evt(src, 1'b0);
         tick(4);
      end

      // reserved mode
      dbg_bus_i = 32'h0;
      tick(4);
      do_arm(2'd3, 5'd0, 1'b0, 32'h0, 32'h0, 2'd0);
      dbg_bus_i = 32'hFFFF_FFFF;
      for (int e = 0; e < 4; e++) set_evt(e, 1'b1);
      tick(2);
      dbg_bus_i = 32'h0;
      for (int e = 0; e < 4; e++) set_evt(e, 1'b0);
      watch(8, seen);
      check("R11", "reserved mode fires", seen, 0);
      check("R11", "still armed", armed_o, 1);
      disarm_i = 1'b1;
      tick(1);
      disarm_i = 1'b0;
      check("R2", "disarm clears", armed_o, 0);

      // configuration changes after arming
      dbg_bus_i = 32'h0;
      tick(4);
      do_arm(2'd0, 5'd3, 1'b0, 32'h0, 32'h0, 2'd0);
      cfg_bit_sel_i = 5'd5; cfg_mode_i = 2'd1; cfg_mask_i = 32'h0;
      dbg_bus_i = 32'h0000_0020;
      watch(4, seen);
      check("R12", "late config used", seen, 0);
      dbg_bus_i = 32'h0000_0028;
      expect_fire("R12", 3);

      // disarm
      dbg_bus_i = 32'h0;
      tick(4);
      do_arm(2'd0, 5'd0, 1'b0, 32'h0, 32'h0, 2'd0);
      disarm_i = 1'b1;
      tick(1);
      disarm_i = 1'b0;
      check("R2", "armed after disarm", armed_o, 0);
      dbg_bus_i = 32'h1;
      watch(5, seen);
      check("R2", "edge while disarmed", seen, 0);
      arm_i = 1'b1; disarm_i = 1'b1;
      tick(1);
      arm_i = 1'b0; disarm_i = 1'b0;
      check("R2", "disarm over arm", armed_o, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule